// File: doc/BRIEF.md
# Spiking Proportional-Integral Error Controller

This block closes the feedback loop around one output class of a single-layer spiking classifier during training. On every timestep strobe it compares a target spike with the spike of the class's output neuron. The difference, a value of -1, 0 or +1, feeds a proportional term and a saturating integral term. Each term is scaled by a programmable power-of-two gain. Their sum is the control signal.

The control signal is split into two rectified halves. The positive half charges an excitatory controller neuron and the negative half charges an inhibitory controller neuron. Both are leaky integrate-and-fire accumulators with a shift-based leak and a common firing threshold. Their spikes return to the output neuron as excitation or inhibition, so over time the positive rate minus the negative rate follows the target-minus-output error. A signed copy of the control signal is registered for the weight-update logic.

When feedback is switched off for inference, the block goes quiet:
- both controller outputs stay low;
- the signed value reads zero;
- the controller membranes are held empty;
- the integral keeps its value until feedback returns.

Top module: `pi_error_controller`

## Requirements
- R1: A synchronous active-high reset drives both controller spikes low and the feedback value to zero, and clears the integral and both membranes. The first enabled strobe after reset with no input spikes therefore reports a feedback value of 0.
- R2: On an enabled strobe the error is targetSpike minus outputSpike. Two coincident spikes, or no spikes, give an error of 0.
- R3: On each enabled strobe the integral adds the error and saturates at +(2^(INT_W-1)-1) and -(2^(INT_W-1)-1). With INT_W=8 the limits are +127 and -127.
- R4: After each enabled strobe the feedback value equals error*2^kpShift + integral*2^kiShift, where the integral already includes the error of that strobe. It is valid in the cycle after the strobe edge.
- R5: Each controller neuron first loses its leak, which is the membrane shifted right by leakShift (a leakShift of 0 means no leak). It then gains its drive. The positive neuron's drive is max(u,0) and the negative neuron's drive is max(-u,0), where u is the value of R4. When the result is at least thresh the neuron spikes and its membrane becomes 0; otherwise the membrane keeps the result.
- R6: A controller spike is a one-cycle pulse in the cycle after an enabled strobe edge, and the two controller spikes are never high together.
- R7: While feedbackEn is low, both spikes are low, the feedback value is 0, both membranes are 0 and the integral is frozen. When feedbackEn returns, the integral continues from its frozen value.
- R8: On a cycle with no strobe, both spikes are low and the feedback value holds its last value.
- R9: With thresh of at least 1, the positive neuron spikes only on a strobe whose control value is positive, and the negative neuron spikes only on a strobe whose control value is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stepStrobe | input | 1 | Timestep strobe; one controller update per strobe |
| feedbackEn | input | 1 | High in training, low in inference |
| targetSpike | input | 1 | Target spike for this timestep |
| outputSpike | input | 1 | Output neuron spike for this timestep |
| kpShift | input | SHIFT_W | Proportional gain exponent |
| kiShift | input | SHIFT_W | Integral gain exponent |
| leakShift | input | SHIFT_W | Membrane leak shift, 0 disables the leak |
| thresh | input | MEM_W | Firing threshold of both controller neurons |
| posSpike | output | 1 | Excitatory feedback spike |
| negSpike | output | 1 | Inhibitory feedback spike |
| fbValue | output | INT_W+2^SHIFT_W | Signed control value for the learning logic |

## Verification
A wrong integral shows up in the feedback value in the cycle right after the next enabled strobe. The integral is added to that value with its own gain, so an off-by-one or a missed saturation is visible straight away rather than only in spike rates.

A wrong membrane or leak cannot be read directly. It shows up as a spike that comes one or more strobes early or late against the arithmetic reference. Sweeping the leak, both gains and the spike patterns therefore exposes leak errors within a few strobes.

A freeze that fails during inference becomes visible on the first strobe after feedback is re-enabled. That strobe carries no error, so the feedback value is exactly the frozen integral scaled by its gain.

// File: rtl/pictrl_pkg.sv
package pictrl_pkg;

  // Strobes passed from the sequencer to the datapath and neurons
  typedef struct packed {
    logic stepFire;   // update the integral, feedback value and membranes
    logic clrInt;     // clear the integral term
    logic clrMem;     // empty both controller membranes
    logic clrOut;     // force spikes low and the feedback value to zero
  } ctrlStrobes_t;

  localparam int unsigned NUM_CTRL = 2;  // index 0 excitatory, 1 inhibitory

endpackage

// File: rtl/pictrl_sequencer.sv
module pictrl_sequencer
  import pictrl_pkg::*;
(
  input  logic         rst,
  input  logic         stepStrobe,
  input  logic         feedbackEn,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes.stepFire = stepStrobe && feedbackEn && !rst;
    strobes.clrInt   = rst;
    strobes.clrMem   = rst || !feedbackEn;
    strobes.clrOut   = rst || !feedbackEn;
  end

endmodule

// File: rtl/pictrl_datapath.sv
module pictrl_datapath
  import pictrl_pkg::*;
#(
  parameter int unsigned INT_W   = 8,
  parameter int unsigned SHIFT_W = 3,
  parameter int unsigned U_W     = INT_W + (1 << SHIFT_W),
  parameter int unsigned DRV_W   = U_W - 1
) (
  input  logic                      clk,
  input  ctrlStrobes_t              strobes,
  input  logic                      targetSpike,
  input  logic                      outputSpike,
  input  logic [SHIFT_W-1:0]        kpShift,
  input  logic [SHIFT_W-1:0]        kiShift,
  output logic [DRV_W-1:0]          drivePos,
  output logic [DRV_W-1:0]          driveNeg,
  output logic signed [U_W-1:0]     fbValue
);

  localparam logic signed [INT_W:0] INT_MAX = (INT_W+1)'((1 << (INT_W-1)) - 1);
  localparam logic signed [INT_W:0] INT_MIN = -INT_MAX;

  logic signed [1:0]       errNow;
  logic signed [INT_W-1:0] integ;
  logic signed [INT_W:0]   integSum;
  logic signed [INT_W-1:0] integNext;
  logic signed [U_W-1:0]   errExt;
  logic signed [U_W-1:0]   intExt;
  logic signed [U_W-1:0]   ctrlSum;
  logic signed [U_W-1:0]   ctrlNeg;

  // error of this timestep: -1, 0 or +1
  always_comb begin
    unique case ({targetSpike, outputSpike})
      2'b10:   errNow = 2'sd1;
      2'b01:   errNow = -2'sd1;
      default: errNow = 2'sd0;
    endcase
  end

  // saturating integral, computed one bit wider to catch the overflow
  always_comb begin
    integSum = {integ[INT_W-1], integ} + {{(INT_W-1){errNow[1]}}, errNow};
    if (integSum > INT_MAX)
      integNext = INT_MAX[INT_W-1:0];
    else if (integSum < INT_MIN)
      integNext = INT_MIN[INT_W-1:0];
    else
      integNext = integSum[INT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strobes.clrInt)
      integ <= '0;
    else if (strobes.stepFire)
      integ <= integNext;
  end

  // proportional plus integral, each scaled by a power-of-two gain
  always_comb begin
    errExt  = {{(U_W-2){errNow[1]}}, errNow};
    intExt  = {{(U_W-INT_W){integNext[INT_W-1]}}, integNext};
    ctrlSum = (errExt <<< kpShift) + (intExt <<< kiShift);
    ctrlNeg = -ctrlSum;
  end

  // rectified halves for the two controller neurons
  always_comb begin
    drivePos = '0;
    driveNeg = '0;
    if (strobes.stepFire) begin
      if (ctrlSum > 0)
        drivePos = ctrlSum[DRV_W-1:0];
      else if (ctrlSum < 0)
        driveNeg = ctrlNeg[DRV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clrOut)
      fbValue <= '0;
    else if (strobes.stepFire)
      fbValue <= ctrlSum;
  end

endmodule

// File: rtl/pictrl_lif.sv
module pictrl_lif
  import pictrl_pkg::*;
#(
  parameter int unsigned MEM_W   = 18,
  parameter int unsigned DRV_W   = 15,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic               clk,
  input  ctrlStrobes_t       strobes,
  input  logic [DRV_W-1:0]   drive,
  input  logic [SHIFT_W-1:0] leakShift,
  input  logic [MEM_W-1:0]   thresh,
  output logic               spike
);

  logic [MEM_W-1:0] mem;
  logic [MEM_W-1:0] leakAmt;
  logic [MEM_W:0]   memSum;
  logic             fire;

  always_comb begin
    leakAmt = (leakShift == '0) ? '0 : (mem >> leakShift);
    memSum  = {1'b0, mem - leakAmt} + {{(MEM_W+1-DRV_W){1'b0}}, drive};
    fire    = memSum >= {1'b0, thresh};
  end

  always_ff @(posedge clk) begin
    if (strobes.clrMem)
      mem <= '0;
    else if (strobes.stepFire)
      mem <= fire ? '0 : memSum[MEM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strobes.clrOut)
      spike <= 1'b0;
    else
      spike <= strobes.stepFire && fire;
  end

endmodule

// File: rtl/pi_error_controller.sv
module pi_error_controller
  import pictrl_pkg::*;
#(
  parameter int unsigned INT_W   = 8,
  parameter int unsigned SHIFT_W = 3,
  parameter int unsigned MEM_W   = 18
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   stepStrobe,
  input  logic                                   feedbackEn,
  input  logic                                   targetSpike,
  input  logic                                   outputSpike,
  input  logic [SHIFT_W-1:0]                     kpShift,
  input  logic [SHIFT_W-1:0]                     kiShift,
  input  logic [SHIFT_W-1:0]                     leakShift,
  input  logic [MEM_W-1:0]                       thresh,
  output logic                                   posSpike,
  output logic                                   negSpike,
  output logic signed [INT_W+(1<<SHIFT_W)-1:0]   fbValue
);

  localparam int unsigned U_W   = INT_W + (1 << SHIFT_W);
  localparam int unsigned DRV_W = U_W - 1;

  ctrlStrobes_t     strobes;
  logic [DRV_W-1:0] drives [NUM_CTRL];
  logic [NUM_CTRL-1:0] spikes;

  pictrl_sequencer u_seq (
    .rst        (rst),
    .stepStrobe (stepStrobe),
    .feedbackEn (feedbackEn),
    .strobes    (strobes)
  );

  pictrl_datapath #(
    .INT_W   (INT_W),
    .SHIFT_W (SHIFT_W),
    .U_W     (U_W),
    .DRV_W   (DRV_W)
  ) u_dp (
    .clk         (clk),
    .strobes     (strobes),
    .targetSpike (targetSpike),
    .outputSpike (outputSpike),
    .kpShift     (kpShift),
    .kiShift     (kiShift),
    .drivePos    (drives[0]),
    .driveNeg    (drives[1]),
    .fbValue     (fbValue)
  );

  for (genvar gi = 0; gi < NUM_CTRL; gi++) begin : g_ctrl
    pictrl_lif #(
      .MEM_W   (MEM_W),
      .DRV_W   (DRV_W),
      .SHIFT_W (SHIFT_W)
    ) u_lif (
      .clk       (clk),
      .strobes   (strobes),
      .drive     (drives[gi]),
      .leakShift (leakShift),
      .thresh    (thresh),
      .spike     (spikes[gi])
    );
  end

  assign posSpike = spikes[0];
  assign negSpike = spikes[1];

endmodule

// File: rtl/pictrl_checker.sv
module pictrl_checker #(
  parameter int unsigned U_W   = 16,
  parameter int unsigned MEM_W = 18
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  stepStrobe,
  input logic                  feedbackEn,
  input logic [MEM_W-1:0]      thresh,
  input logic                  posSpike,
  input logic                  negSpike,
  input logic signed [U_W-1:0] fbValue
);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!posSpike && !negSpike && fbValue == '0));

  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(posSpike && negSpike));

  p_pulse_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    (posSpike || negSpike) |-> $past(stepStrobe));

  p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(feedbackEn) |-> (!posSpike && !negSpike && fbValue == '0));

  p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(stepStrobe) && $past(feedbackEn) && !$past(rst))
      |-> (fbValue == $past(fbValue) && !posSpike && !negSpike));

  p_pos_sign_r9: assert property (@(posedge clk) disable iff (rst)
    (posSpike && thresh != '0 && $stable(thresh)) |-> fbValue > 0);

  p_neg_sign_r9: assert property (@(posedge clk) disable iff (rst)
    (negSpike && thresh != '0 && $stable(thresh)) |-> fbValue < 0);

endmodule

bind pi_error_controller pictrl_checker #(
  .U_W   (U_W),
  .MEM_W (MEM_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stepStrobe (stepStrobe),
  .feedbackEn (feedbackEn),
  .thresh     (thresh),
  .posSpike   (posSpike),
  .negSpike   (negSpike),
  .fbValue    (fbValue)
);

// File: tb/tb_pi_error_controller.sv
module tb_pi_error_controller;

  localparam int INT_W   = 8;
  localparam int SHIFT_W = 3;
  localparam int MEM_W   = 18;
  localparam int U_W     = INT_W + (1 << SHIFT_W);
  localparam int IMAX    = (1 << (INT_W-1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stepStrobe = 1'b0;
  logic feedbackEn = 1'b1;
  logic targetSpike = 1'b0;
  logic outputSpike = 1'b0;
  logic [SHIFT_W-1:0] kpShift = '0;
  logic [SHIFT_W-1:0] kiShift = '0;
  logic [SHIFT_W-1:0] leakShift = '0;
  logic [MEM_W-1:0]   thresh = 18'd40;
  logic posSpike, negSpike;
  logic signed [U_W-1:0] fbValue;

  int checks = 0;
  int errors = 0;
  int mInt = 0, mMemP = 0, mMemN = 0, mFb = 0;
  bit mPos = 0, mNeg = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pi_error_controller #(.INT_W(INT_W), .SHIFT_W(SHIFT_W), .MEM_W(MEM_W)) dut (
    .clk(clk), .rst(rst), .stepStrobe(stepStrobe), .feedbackEn(feedbackEn),
    .targetSpike(targetSpike), .outputSpike(outputSpike),
    .kpShift(kpShift), .kiShift(kiShift), .leakShift(leakShift),
    .thresh(thresh), .posSpike(posSpike), .negSpike(negSpike), .fbValue(fbValue)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void lifStep(ref int mem, input int drv, output bit fired);
    int lk, s;
    lk = (leakShift == 0) ? 0 : (mem >> leakShift);
    s = mem - lk + drv;
    fired = (s >= int'(thresh));
    mem = fired ? 0 : s;
  endfunction

  // one clock: inputs applied at a falling edge, result compared at the next one
  task automatic tick(bit t, bit o, bit s, string fbTag, string spTag);
    int err, u;
    bit fp, fn;
    targetSpike = t; outputSpike = o; stepStrobe = s;
    @(negedge clk);
    if (rst) begin
      mInt = 0; mMemP = 0; mMemN = 0; mFb = 0; mPos = 0; mNeg = 0;
    end else if (!feedbackEn) begin
      mMemP = 0; mMemN = 0; mFb = 0; mPos = 0; mNeg = 0;
    end else if (s) begin
      err = int'(t) - int'(o);
      mInt = mInt + err;
      if (mInt > IMAX) mInt = IMAX;
      if (mInt < -IMAX) mInt = -IMAX;
      u = err * (1 << kpShift) + mInt * (1 << kiShift);
      mFb = u;
      lifStep(mMemP, (u > 0) ? u : 0, fp);
      lifStep(mMemN, (u < 0) ? -u : 0, fn);
      mPos = fp; mNeg = fn;
    end else begin
      mPos = 0; mNeg = 0;
    end
    check(int'(fbValue) == mFb, fbTag, "fbValue", int'(fbValue), mFb);
    check(posSpike === mPos, spTag, "posSpike", int'(posSpike), int'(mPos));
    check(negSpike === mNeg, spTag, "negSpike", int'(negSpike), int'(mNeg));
    check(!(posSpike && negSpike), "R6", "both spikes", 1, 0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick(0, 0, 0, "R1", "R1");
    tick(1, 0, 1, "R1", "R1");
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    @(negedge clk);
    doReset();
    // R1: first enabled strobe after reset with no spikes reads 0
    tick(0, 0, 1, "R1", "R1");

    // R2: error encoding, kp=2 ki=0
    kpShift = 3'd2; kiShift = 3'd0; thresh = 18'd1000;
    doReset();
    tick(1, 1, 1, "R2", "R5");   // 0
    tick(1, 0, 1, "R2", "R5");   // 4 + 1 = 5
    tick(0, 1, 1, "R2", "R5");   // -4 + 0 = -4
    tick(0, 0, 1, "R2", "R5");   // 0

    // R8: holds between strobes
    tick(1, 0, 1, "R4", "R5");
    for (int k = 0; k < 4; k++) tick(1, 0, 0, "R8", "R8");

    // R3: saturation both ways, unit gains
    kpShift = 3'd0; kiShift = 3'd0; thresh = 18'd100000;
    doReset();
    for (int k = 0; k < 140; k++) tick(1, 0, 1, "R3", "R5");
    check(int'(fbValue) == IMAX + 1, "R3", "upper limit", int'(fbValue), IMAX + 1);
    for (int k = 0; k < 300; k++) tick(0, 1, 1, "R3", "R5");
    check(int'(fbValue) == -IMAX - 1, "R3", "lower limit", int'(fbValue), -IMAX - 1);

    // R9: sign of spiking follows sign of the control value
    thresh = 18'd3; leakShift = 3'd0;
    doReset();
    for (int k = 0; k < 6; k++) tick(1, 0, 1, "R4", "R9");
    for (int k = 0; k < 12; k++) tick(0, 1, 1, "R4", "R9");

    // R7: inference freezes the integral and silences the outputs
    kiShift = 3'd2; thresh = 18'd20;
    doReset();
    for (int k = 0; k < 5; k++) tick(1, 0, 1, "R4", "R5");
    feedbackEn = 1'b0;
    for (int k = 0; k < 6; k++) tick(k[0], !k[0], 1, "R7", "R7");
    feedbackEn = 1'b1;
    tick(0, 0, 1, "R7", "R7");   // frozen integral 5, scaled by 4
    check(int'(fbValue) == 20, "R7", "frozen integral", int'(fbValue), 20);

    // sweep: gains, leak and spike densities (R4, R5)
    for (int kp = 0; kp < 4; kp++) begin
      for (int ki = 0; ki < 4; ki++) begin
        for (int lk = 0; lk < 3; lk++) begin
          kpShift = kp[SHIFT_W-1:0];
          kiShift = ki[SHIFT_W-1:0];
          leakShift = (lk == 2) ? 3'd3 : lk[SHIFT_W-1:0];
          thresh = 18'd40;
          doReset();
          for (int k = 0; k < 40; k++) begin
            bit tt, oo, ss;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tt = (k < 20) ? (lfsr[2:0] != 3'd0) : (lfsr[2:0] == 3'd0);
            oo = lfsr[5] & lfsr[4];
            ss = (lfsr[9:8] != 2'd0);
            tick(tt, oo, ss, ss ? "R4" : "R8", "R5");
          end
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule